// File: doc/BRIEF.md
# Credit-Based Inter-Processor Message Thread

This block is one thread of a message proxy that moves fixed-size messages between two processors. A thread has a single direction, chosen by a bit in its control register. As a transmit thread it collects a message in its data registers and hands the whole message to the fabric once the last word is written. It tracks how many message slots the far side still has free (credits); the paired receiver returns credits as it consumes messages. As a receive thread it holds incoming messages in a small queue, reports how many are pending, raises an interrupt while any are waiting, and releases a message when the last data word is read. That release also returns one credit to the sender as a single-cycle pulse.

The host reaches the thread through a simple single-cycle register port with a one-cycle registered read. A message is fifteen 32-bit words. A protocol violation sets a sticky error flag: sending without credit, reading with nothing pending, or an incoming message with no room left. While the flag is set, sends and reads are refused. Software clears it by writing one to it.

Top module: `credit_proxy_thread`

## Requirements
- R1: After reset the thread is a transmit thread (control bit 31 = 0), the status count equals DEPTH (4 by default), the error flag is 0 and the receive interrupt is low.
- R2: Byte offsets inside the thread window. Status is at 0x000, with the count in bits 7:0 and the error flag in bit 31. Data word i (i = 0..14) is at 0x004 + 4*i, so the last word is at 0x03C. Control is at 0x1000, where bit 31 gives the direction (1 = receive, 0 = transmit). Reads return data one cycle after the request.
- R3: In transmit mode, writing data word 14 with credit available emits a one-cycle `tx_msg_valid`. `tx_msg_data` carries word i in bits 32*i+31:32*i, and word 14 is the value just written. The credit count drops by one.
- R4: In transmit mode, writing word 14 with zero credits sends nothing, leaves the count at 0 and sets the error flag.
- R5: In transmit mode a `credit_ret_in` pulse adds one credit, saturating at DEPTH. In receive mode the pulse is ignored.
- R6: Writing control bit 31 with a value different from the current direction switches the direction and reloads the thread: receive gives count 0, transmit gives count DEPTH. The error flag is cleared and queued messages are discarded. Writing the current direction changes nothing.
- R7: In receive mode, each `rx_push_valid` stores one message (same word layout as R3), and the status count equals the number of pending messages. `rx_irq` is high exactly while the thread is in receive mode with a nonzero count, and it updates together with the count.
- R8: In receive mode, reading data word i returns word i of the oldest pending message. Reading word 14 consumes that message: the count drops by one and `credit_ret_out` pulses for one cycle. Messages leave in arrival order.
- R9: Reading word 14 with no pending message sets the error flag, consumes nothing and gives no credit pulse. A push arriving when DEPTH messages are pending is dropped and sets the error flag.
- R10: While the error flag is set, sends and consumes are refused: no message goes out, the count is not decremented and there is no credit pulse. Writing status with bit 31 = 1 clears the flag.
- R11: In transmit mode `rx_push_valid` is ignored. The count and the interrupt do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte offset inside the thread window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| tx_msg_valid | output | 1 | One-cycle pulse: a message is sent |
| tx_msg_data | output | 480 | Sent message, word i at bits 32*i+31:32*i |
| credit_ret_in | input | 1 | Credit returned by the far receiver |
| rx_push_valid | input | 1 | Incoming message strobe |
| rx_push_data | input | 480 | Incoming message, same word layout |
| credit_ret_out | output | 1 | One-cycle pulse: a received message was consumed |
| rx_irq | output | 1 | High while receive messages are pending |

## Verification
The hardest situation to reach is the error flag being set while the thread still holds credits or messages, because that is when the blocking rule actually matters. The stimulus first drains the credits and sends once more to raise the error, then returns a credit so a send would be legal apart from the flag. On the receive side it overfills the queue so that DEPTH messages wait behind a set flag. It then shows that the refused send and the refused consume leave the count and the pulses untouched, and that they work again after the flag is cleared.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned FLAG_BIT = 31;
  localparam int unsigned CNT_FLD  = 8;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_DATA   = 2'd2,
    SEL_CTRL   = 2'd3
  } sel_e;
endpackage

// File: rtl/cpt_decode.sv
module cpt_decode
  import cpt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned NUM_WORDS = 15,
  parameter int unsigned IDX_W     = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [IDX_W-1:0]  idx,
  output logic              last
);
  localparam int unsigned WI_W = ADDR_W - 3;

  logic [WI_W-1:0] wi;
  assign wi = addr[ADDR_W-2:2];

  always_comb begin
    sel  = SEL_NONE;
    idx  = '0;
    last = 1'b0;
    if (addr[1:0] == 2'b00) begin
      if (addr[ADDR_W-1]) begin
        if (wi == '0) sel = SEL_CTRL;
      end else if (wi == '0) begin
        sel = SEL_STATUS;
      end else if (wi <= WI_W'(NUM_WORDS)) begin
        sel  = SEL_DATA;
        idx  = IDX_W'(wi - WI_W'(1));
        last = (wi == WI_W'(NUM_WORDS));
      end
    end
  end
endmodule

// File: rtl/cpt_counter.sv
module cpt_counter #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reset_rx,
  input  logic             dir_rx,
  input  logic             load,
  input  logic             load_rx,
  input  logic             send_req,
  input  logic             pop_req,
  input  logic             push_req,
  input  logic             cr_in,
  input  logic             err_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             err,
  output logic             irq,
  output logic             send_ok,
  output logic             pop_ok,
  output logic             push_ok
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic             ret_ok;
  logic             err_set;
  logic             inc;
  logic             dec;
  logic [CNT_W-1:0] cnt_d;
  logic             err_d;
  logic             irq_d;

  always_comb begin
    send_ok = !load && !dir_rx && send_req && (cnt != '0) && !err;
    pop_ok  = !load &&  dir_rx && pop_req  && (cnt != '0) && !err;
    push_ok = !load &&  dir_rx && push_req && (cnt != FULL);
    ret_ok  = !load && !dir_rx && cr_in    && (cnt != FULL);
    err_set = !load && ((!dir_rx && send_req && (cnt == '0)) ||
                        ( dir_rx && pop_req  && (cnt == '0)) ||
                        ( dir_rx && push_req && (cnt == FULL)));
    inc = push_ok | ret_ok;
    dec = send_ok | pop_ok;
    if (load)          cnt_d = load_rx ? '0 : FULL;
    else if (inc && !dec) cnt_d = cnt + 1'b1;
    else if (dec && !inc) cnt_d = cnt - 1'b1;
    else               cnt_d = cnt;
    if (load)          err_d = 1'b0;
    else if (err_set)  err_d = 1'b1;
    else if (err_clr)  err_d = 1'b0;
    else               err_d = err;
    irq_d = load ? 1'b0 : (dir_rx && (cnt_d != '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= reset_rx ? '0 : FULL;
      err <= 1'b0;
      irq <= 1'b0;
    end else begin
      cnt <= cnt_d;
      err <= err_d;
      irq <= irq_d;
    end
  end

  AST_TX_CREDIT_DROP: assert property (@(posedge clk) disable iff (rst)
    (send_ok && !ret_ok) |=> (cnt == $past(cnt) - 1'b1)); // R3
  AST_EMPTY_SEND_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (send_req && !dir_rx && !load && (cnt == '0)) |=> err); // R4
  AST_CREDIT_CEILING: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL); // R5
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    load |=> (!err && (cnt == (dir_rx ? '0 : FULL)))); // R6
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    irq == (dir_rx && (cnt != '0))); // R7
endmodule

// File: rtl/cpt_tx_stage.sv
module cpt_tx_stage #(
  parameter int unsigned NUM_WORDS = 15,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IDX_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        send_ok,
  output logic                        msg_valid,
  output logic [NUM_WORDS*DATA_W-1:0] msg_data
);
  localparam int unsigned MSG_W = NUM_WORDS * DATA_W;

  logic [DATA_W-1:0] stage_q [NUM_WORDS-1];
  logic [MSG_W-1:0]  msg_next;

  for (genvar w = 0; w < NUM_WORDS - 1; w++) begin : g_stage
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(w))) stage_q[w] <= wr_data;
    end
    assign msg_next[w*DATA_W +: DATA_W] = stage_q[w];
  end
  assign msg_next[MSG_W-1 -: DATA_W] = wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_data  <= '0;
    end else begin
      msg_valid <= send_ok;
      if (send_ok) msg_data <= msg_next;
    end
  end

  AST_MSG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !send_ok |=> $stable(msg_data)); // R3
endmodule

// File: rtl/cpt_rx_store.sv
module cpt_rx_store #(
  parameter int unsigned NUM_WORDS = 15,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned IDX_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flush,
  input  logic                        push_ok,
  input  logic [NUM_WORDS*DATA_W-1:0] push_data,
  input  logic                        pop_ok,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [DATA_W-1:0]           rd_word
);
  localparam int unsigned MSG_W = NUM_WORDS * DATA_W;
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [MSG_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [OCC_W-1:0] occ;
  logic [MSG_W-1:0] head;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      if (push_ok && !pop_ok)      occ <= occ + 1'b1;
      else if (pop_ok && !push_ok) occ <= occ - 1'b1;
    end
  end

  assign head    = mem[rd_ptr];
  assign rd_word = head[rd_idx*DATA_W +: DATA_W];

  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    pop_ok |-> (occ != '0)); // R8
  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (rst)
    push_ok |-> (occ != OCC_W'(DEPTH))); // R9
endmodule

// File: rtl/credit_proxy_thread.sv
module credit_proxy_thread
  import cpt_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 15,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned ADDR_W    = 13,
  parameter bit          RESET_RX  = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_req,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic                        bus_rvalid,
  output logic                        tx_msg_valid,
  output logic [NUM_WORDS*DATA_W-1:0] tx_msg_data,
  input  logic                        credit_ret_in,
  input  logic                        rx_push_valid,
  input  logic [NUM_WORDS*DATA_W-1:0] rx_push_data,
  output logic                        credit_ret_out,
  output logic                        rx_irq
);
  localparam int unsigned IDX_W = $clog2(NUM_WORDS);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  sel_e             sel;
  logic [IDX_W-1:0] idx;
  logic             last;
  logic             dir_q;
  logic             load;
  logic             wr_any;
  logic             rd_any;
  logic             send_req;
  logic             pop_req;
  logic             err_clr;
  logic [CNT_W-1:0] cnt;
  logic             err;
  logic             send_ok;
  logic             pop_ok;
  logic             push_ok;
  logic [DATA_W-1:0] rx_word;
  logic [DATA_W-1:0] rd_mux;

  cpt_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_dec (
    .addr(bus_addr), .sel(sel), .idx(idx), .last(last)
  );

  assign wr_any   = bus_req &&  bus_we;
  assign rd_any   = bus_req && !bus_we;
  assign load     = wr_any && (sel == SEL_CTRL) && (bus_wdata[FLAG_BIT] != dir_q);
  assign send_req = wr_any && (sel == SEL_DATA) && last && !dir_q;
  assign pop_req  = rd_any && (sel == SEL_DATA) && last &&  dir_q;
  assign err_clr  = wr_any && (sel == SEL_STATUS) && bus_wdata[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst)       dir_q <= RESET_RX;
    else if (load) dir_q <= bus_wdata[FLAG_BIT];
  end

  cpt_counter #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .reset_rx(RESET_RX), .dir_rx(dir_q),
    .load(load), .load_rx(bus_wdata[FLAG_BIT]),
    .send_req(send_req), .pop_req(pop_req), .push_req(rx_push_valid),
    .cr_in(credit_ret_in), .err_clr(err_clr),
    .cnt(cnt), .err(err), .irq(rx_irq),
    .send_ok(send_ok), .pop_ok(pop_ok), .push_ok(push_ok)
  );

  cpt_tx_stage #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_tx (
    .clk(clk), .rst(rst),
    .wr_en(wr_any && (sel == SEL_DATA) && !dir_q),
    .wr_idx(idx), .wr_data(bus_wdata), .send_ok(send_ok),
    .msg_valid(tx_msg_valid), .msg_data(tx_msg_data)
  );

  cpt_rx_store #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst(rst), .flush(load),
    .push_ok(push_ok), .push_data(rx_push_data), .pop_ok(pop_ok),
    .rd_idx(idx), .rd_word(rx_word)
  );

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_STATUS: begin
        rd_mux[FLAG_BIT]  = err;
        rd_mux[CNT_W-1:0] = cnt;
      end
      SEL_DATA: rd_mux = dir_q ? rx_word : '0;
      SEL_CTRL: rd_mux[FLAG_BIT] = dir_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata      <= '0;
      bus_rvalid     <= 1'b0;
      credit_ret_out <= 1'b0;
    end else begin
      bus_rvalid     <= rd_any;
      credit_ret_out <= pop_ok;
      if (rd_any) bus_rdata <= rd_mux;
    end
  end

  AST_CRET_RX_ONLY: assert property (@(posedge clk) disable iff (rst)
    credit_ret_out |-> dir_q); // R8
  AST_ERR_NO_SEND: assert property (@(posedge clk) disable iff (rst)
    (err && send_req) |=> !tx_msg_valid); // R10
  AST_TX_IGNORES_PUSH: assert property (@(posedge clk) disable iff (rst)
    (!dir_q && !load) |=> !rx_irq); // R11
endmodule

// File: tb/tb_credit_proxy_thread.sv
`timescale 1ns/1ps
module tb_credit_proxy_thread;
  localparam int NW    = 15;
  localparam int MSG_W = NW * 32;

  logic             clk = 1'b0;
  logic             rst;
  logic             bus_req = 1'b0;
  logic             bus_we = 1'b0;
  logic [12:0]      bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic             bus_rvalid;
  logic             tx_msg_valid;
  logic [MSG_W-1:0] tx_msg_data;
  logic             credit_ret_in = 1'b0;
  logic             rx_push_valid = 1'b0;
  logic [MSG_W-1:0] rx_push_data = '0;
  logic             credit_ret_out;
  logic             rx_irq;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic             seen_txv;
  logic             seen_cret;
  logic [MSG_W-1:0] seen_msg;
  logic [31:0]      rv;

  always #2 clk = ~clk;

  credit_proxy_thread dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .tx_msg_valid(tx_msg_valid), .tx_msg_data(tx_msg_data),
    .credit_ret_in(credit_ret_in), .rx_push_valid(rx_push_valid),
    .rx_push_data(rx_push_data), .credit_ret_out(credit_ret_out), .rx_irq(rx_irq)
  );

  function automatic logic [MSG_W-1:0] mk_msg(input logic [31:0] base);
    logic [MSG_W-1:0] m;
    for (int i = 0; i < NW; i++) m[i*32 +: 32] = base + 32'(i);
    return m;
  endfunction

  function automatic logic [12:0] dreg(input int i);
    return 13'(4 + 4 * i);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [MSG_W-1:0] act,
                       input logic [MSG_W-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, tag, MSG_W'(act), MSG_W'(exp));
  endtask

  task automatic bus_wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    seen_txv = tx_msg_valid; seen_cret = credit_ret_out; seen_msg = tx_msg_data;
  endtask

  task automatic bus_rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata; seen_cret = credit_ret_out; seen_txv = tx_msg_valid;
  endtask

  task automatic send_msg(input logic [MSG_W-1:0] m);
    for (int i = 0; i < NW; i++) bus_wr(dreg(i), m[i*32 +: 32]);
  endtask

  task automatic cr_pulse();
    @(negedge clk); credit_ret_in = 1'b1;
    @(negedge clk); credit_ret_in = 1'b0;
  endtask

  task automatic push(input logic [MSG_W-1:0] m);
    @(negedge clk); rx_push_valid = 1'b1; rx_push_data = m;
    @(negedge clk); rx_push_valid = 1'b0;
  endtask

  task automatic expect_status(input string tag, input logic [31:0] exp);
    logic [31:0] s;
    bus_rd(13'h000, s);
    chk32(tag, s, exp);
  endtask

  task automatic t_reset();
    chk32("R1 irq after reset", 32'(rx_irq), 32'd0);
    bus_rd(13'h1000, rv);
    chk32("R1/R2 ctrl after reset", rv, 32'h0);
    expect_status("R1/R2 status after reset", 32'd4);
  endtask

  task automatic t_tx_send();
    logic [MSG_W-1:0] m;
    m = mk_msg(32'hA000_0000);
    send_msg(m);
    chk32("R3 tx_msg_valid pulse", 32'(seen_txv), 32'd1);
    check(seen_msg === m, "R3 tx_msg_data", seen_msg, m);
    @(negedge clk);
    chk32("R3 tx_msg_valid single cycle", 32'(tx_msg_valid), 32'd0);
    expect_status("R3 credit decrement", 32'd3);
  endtask

  task automatic t_tx_exhaust();
    for (int k = 0; k < 3; k++) send_msg(mk_msg(32'hB000_0000 + 32'(k << 8)));
    expect_status("R3 credits drained", 32'd0);
    send_msg(mk_msg(32'hC000_0000));
    chk32("R4 no send at zero credit", 32'(seen_txv), 32'd0);
    expect_status("R4 error set, count 0", 32'h8000_0000);
    cr_pulse();
    expect_status("R5 credit returns under error", 32'h8000_0001);
    send_msg(mk_msg(32'hD000_0000));
    chk32("R10 send refused under error", 32'(seen_txv), 32'd0);
    expect_status("R10 count kept under error", 32'h8000_0001);
    bus_wr(13'h000, 32'h8000_0000);
    expect_status("R10 error cleared", 32'd1);
    send_msg(mk_msg(32'hE000_0000));
    chk32("R10 send works after clear", 32'(seen_txv), 32'd1);
    expect_status("R10 count after send", 32'd0);
  endtask

  task automatic t_credit_sat();
    for (int k = 0; k < 6; k++) cr_pulse();
    expect_status("R5 credits saturate at DEPTH", 32'd4);
  endtask

  task automatic t_push_in_tx();
    push(mk_msg(32'h1111_0000));
    @(negedge clk);
    chk32("R11 irq stays low in tx", 32'(rx_irq), 32'd0);
    expect_status("R11 push ignored in tx", 32'd4);
  endtask

  task automatic t_dir_rx();
    bus_wr(13'h1000, 32'h8000_0000);
    bus_rd(13'h1000, rv);
    chk32("R6 ctrl reads receive", rv, 32'h8000_0000);
    expect_status("R6 reload to zero in rx", 32'd0);
  endtask

  task automatic t_rx_flow();
    logic [MSG_W-1:0] b;
    logic [MSG_W-1:0] c;
    b = mk_msg(32'h2000_0000);
    c = mk_msg(32'h3000_0000);
    push(b);
    chk32("R7 irq with one pending", 32'(rx_irq), 32'd1);
    push(c);
    expect_status("R7 pending count 2", 32'd2);
    bus_rd(dreg(3), rv);
    chk32("R8 head word 3", rv, b[3*32 +: 32]);
    chk32("R8 no pulse on non-last read", 32'(seen_cret), 32'd0);
    bus_rd(dreg(14), rv);
    chk32("R8 head word 14", rv, b[14*32 +: 32]);
    chk32("R8 credit_ret_out pulse", 32'(seen_cret), 32'd1);
    expect_status("R8 count after consume", 32'd1);
    bus_rd(dreg(0), rv);
    chk32("R8 order: next message word 0", rv, c[31:0]);
    bus_rd(dreg(14), rv);
    chk32("R8 second consume pulse", 32'(seen_cret), 32'd1);
    chk32("R7 irq drops at zero", 32'(rx_irq), 32'd0);
  endtask

  task automatic t_rx_errors();
    bus_rd(dreg(14), rv);
    chk32("R9 no pulse on empty read", 32'(seen_cret), 32'd0);
    expect_status("R9 error on empty read", 32'h8000_0000);
    bus_wr(13'h000, 32'h8000_0000);
    for (int k = 0; k < 5; k++) push(mk_msg(32'h4000_0000 + 32'(k << 8)));
    expect_status("R9 overflow dropped, error set", 32'h8000_0004);
    bus_rd(dreg(14), rv);
    chk32("R10 consume refused under error", 32'(seen_cret), 32'd0);
    expect_status("R10 pending kept under error", 32'h8000_0004);
    bus_wr(13'h000, 32'h8000_0000);
    bus_rd(dreg(0), rv);
    chk32("R9 first message kept, not the dropped one", rv, 32'h4000_0000);
    cr_pulse();
    expect_status("R5 credit_ret_in ignored in rx", 32'd4);
  endtask

  task automatic t_dir_same_and_back();
    bus_wr(13'h1000, 32'h8000_0000);
    expect_status("R6 same direction no reload", 32'd4);
    bus_wr(13'h1000, 32'h0);
    expect_status("R6 reload to DEPTH in tx", 32'd4);
    chk32("R6 irq low in tx", 32'(rx_irq), 32'd0);
    bus_wr(13'h1000, 32'h8000_0000);
    expect_status("R6 queued messages discarded", 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tx_send();
    t_tx_exhaust();
    t_credit_sat();
    t_push_in_tx();
    t_dir_rx();
    t_rx_flow();
    t_rx_errors();
    t_dir_same_and_back();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule